// File: doc/BRIEF.md
# CPU Status Flag Unit with Pushed-Byte Image

This block is the condition-flag unit of an 8-bit processor. It keeps six flags: carry, zero, interrupt-disable, decimal, overflow and negative. From them it forms the byte that the core writes to the stack whenever status is saved.

The pushed byte carries two bits that have no storage. One is a constant 1. The other is a break marker whose value depends only on what caused the push: a software status push, a break instruction or a hardware interrupt.

The unit also restores flags from a byte pulled off the stack, and it recomputes negative and zero when a byte is pulled into the accumulator. Individual set and clear masks let the surrounding core change single flags.

Instruction decode, the stack pointer and the memory port all sit outside the block. The core presents the push source, samples `stackImage` in the cycle it writes the stack, and raises the pull strobes together with the data read back.

Top module: `cpu_flag_unit`

## Requirements
- R1: Reset (active-low `rstN`) leaves interrupt-disable set and every other flag clear, so `statusFlags` reads 0x04 and a software push image reads 0x34.
- R2: `stackImage` is combinational on the present flags. Its layout is negative at bit 7, overflow at bit 6, constant 1 at bit 5, break marker at bit 4, decimal at bit 3, interrupt-disable at bit 2, zero at bit 1 and carry at bit 0. `statusFlags` uses the same positions, with bits 5 and 4 always 0.
- R3: `pushSrc` selects the push cause: 0 is a software push, 1 is a break instruction, 2 is a hardware interrupt and 3 acts as a software push. The break marker is 0 only for code 2.
- R4: `pullStatusStb` loads bits 7, 6, 3, 2, 1 and 0 of `pullStatusData` into the flags on the next edge. Bits 5 and 4 of that byte are discarded.
- R5: After status is restored from 0x00, a software push image is 0x30.
- R6: `pullAccStb` sets zero when `pullAccData` is 0x00 and copies its bit 7 into negative. The other four flags are unchanged.
- R7: Pulling the 0x30 image into the accumulator leaves zero clear.
- R8: A push (`pushReq`) with code 1 or 2 sets interrupt-disable on the following edge. The image in the push cycle shows the earlier value. A software push leaves interrupt-disable as it was.
- R9: `flagSetMask` and `flagClrMask` use the R2 bit positions. A set wins over a clear on the same bit, and mask bits 5 and 4 have no effect.
- R10: When `pullStatusStb` is high, the flags take the pulled byte, regardless of any accumulator pull, push or mask in the same cycle.
- R11: Without a status pull, an accumulator pull decides negative and zero over the masks, and a break or interrupt push sets interrupt-disable over a clear mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Status is being pushed this cycle |
| pushSrc | input | 2 | Push cause code (R3) |
| pullStatusStb | input | 1 | Restore flags from stack byte |
| pullStatusData | input | 8 | Byte pulled into status |
| pullAccStb | input | 1 | Byte pulled into accumulator |
| pullAccData | input | 8 | Byte pulled into accumulator |
| flagSetMask | input | 8 | Per-flag set controls |
| flagClrMask | input | 8 | Per-flag clear controls |
| statusFlags | output | 8 | Live flags, bits 5 and 4 read 0 |
| stackImage | output | 8 | Byte to write when status is pushed |

## Verification
The hardest situation to reach from the ports is a single cycle in which every update path contends: a status pull, an accumulator pull, an interrupt push and both masks at once. The stimulus table holds such cycles, with data chosen so that each losing path would leave a visibly different byte. A restore from 0x00 followed by a software push and an accumulator pull of that 0x30 image reproduces the case where the zero flag must stay clear. Break and interrupt pushes are checked before and after the edge, which separates the image's earlier interrupt-disable from its later set value.

// File: rtl/cpu_flag_pkg.sv
package cpu_flag_pkg;
  localparam int BYTE_W   = 8;
  localparam int POS_C    = 0;
  localparam int POS_Z    = 1;
  localparam int POS_I    = 2;
  localparam int POS_D    = 3;
  localparam int POS_BRK  = 4;
  localparam int POS_ONE  = 5;
  localparam int POS_V    = 6;
  localparam int POS_N    = 7;

  localparam logic [1:0] SRC_SOFT = 2'd0;
  localparam logic [1:0] SRC_BRK  = 2'd1;
  localparam logic [1:0] SRC_IRQ  = 2'd2;

  // bits that exist in registers (everything but break and the fixed one)
  localparam logic [BYTE_W-1:0] STORED_MASK = 8'hCF;
  localparam logic [BYTE_W-1:0] RESET_FLAGS = 8'h04;

  typedef struct packed {
    logic              loadAll;
    logic [BYTE_W-1:0] loadByte;
    logic              loadNZ;
    logic              nzNeg;
    logic              nzZero;
    logic              forceI;
    logic [BYTE_W-1:0] setBits;
    logic [BYTE_W-1:0] clrBits;
  } flagStrobes_t;
endpackage

// File: rtl/cpu_flag_ctrl.sv
module cpu_flag_ctrl
  import cpu_flag_pkg::*;
(
  input  logic              pushReq,
  input  logic [1:0]        pushSrc,
  input  logic              pullStatusStb,
  input  logic [BYTE_W-1:0] pullStatusData,
  input  logic              pullAccStb,
  input  logic [BYTE_W-1:0] pullAccData,
  input  logic [BYTE_W-1:0] flagSetMask,
  input  logic [BYTE_W-1:0] flagClrMask,
  output flagStrobes_t      strobes
);
  logic causeSetsI;
  logic [BYTE_W-1:0] nzKeep;
  logic [BYTE_W-1:0] iKeep;

  assign causeSetsI = pushReq && (pushSrc == SRC_BRK || pushSrc == SRC_IRQ);

  always_comb begin
    nzKeep = STORED_MASK;
    if (pullAccStb) begin
      nzKeep[POS_N] = 1'b0;
      nzKeep[POS_Z] = 1'b0;
    end
    iKeep = '1;
    if (causeSetsI) iKeep[POS_I] = 1'b0;
  end

  always_comb begin
    strobes = '0;
    if (pullStatusStb) begin
      strobes.loadAll  = 1'b1;
      strobes.loadByte = pullStatusData & STORED_MASK;
    end else begin
      strobes.loadNZ  = pullAccStb;
      strobes.nzNeg   = pullAccData[POS_N];
      strobes.nzZero  = (pullAccData == '0);
      strobes.forceI  = causeSetsI;
      strobes.setBits = flagSetMask & nzKeep;
      strobes.clrBits = flagClrMask & nzKeep & iKeep;
    end
  end
endmodule

// File: rtl/cpu_flag_dp.sv
module cpu_flag_dp
  import cpu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobes_t      strobes,
  input  logic [1:0]        pushSrc,
  output logic [BYTE_W-1:0] statusFlags,
  output logic [BYTE_W-1:0] stackImage
);
  logic [BYTE_W-1:0] flagQ;
  logic [BYTE_W-1:0] flagD;

  always_comb begin
    flagD = flagQ;
    if (strobes.loadAll) begin
      flagD = strobes.loadByte;
    end else begin
      flagD = (flagQ & ~strobes.clrBits) | strobes.setBits;
      if (strobes.loadNZ) begin
        flagD[POS_N] = strobes.nzNeg;
        flagD[POS_Z] = strobes.nzZero;
      end
      if (strobes.forceI) flagD[POS_I] = 1'b1;
    end
    flagD = flagD & STORED_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= RESET_FLAGS;
    else       flagQ <= flagD;
  end

  always_comb begin
    stackImage          = flagQ;
    stackImage[POS_ONE] = 1'b1;
    stackImage[POS_BRK] = (pushSrc != SRC_IRQ);
  end

  assign statusFlags = flagQ;
endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit
  import cpu_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pushReq,
  input  logic [1:0]  pushSrc,
  input  logic        pullStatusStb,
  input  logic [7:0]  pullStatusData,
  input  logic        pullAccStb,
  input  logic [7:0]  pullAccData,
  input  logic [7:0]  flagSetMask,
  input  logic [7:0]  flagClrMask,
  output logic [7:0]  statusFlags,
  output logic [7:0]  stackImage
);
  flagStrobes_t strobes;

  cpu_flag_ctrl ctrl_i (
    .pushReq(pushReq), .pushSrc(pushSrc),
    .pullStatusStb(pullStatusStb), .pullStatusData(pullStatusData),
    .pullAccStb(pullAccStb), .pullAccData(pullAccData),
    .flagSetMask(flagSetMask), .flagClrMask(flagClrMask),
    .strobes(strobes)
  );

  cpu_flag_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pushSrc(pushSrc),
    .statusFlags(statusFlags), .stackImage(stackImage)
  );
endmodule

// File: rtl/cpu_flag_unit_chk.sv
module cpu_flag_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pushReq,
  input logic [1:0] pushSrc,
  input logic       pullStatusStb,
  input logic [7:0] pullStatusData,
  input logic       pullAccStb,
  input logic [7:0] pullAccData,
  input logic [7:0] statusFlags,
  input logic [7:0] stackImage
);
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> statusFlags == 8'h04);

  p_fixed_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    stackImage[5] == 1'b1 && statusFlags[5:4] == 2'b00);

  p_break_marker_r3: assert property (@(posedge clk) disable iff (!rstN)
    stackImage[4] == (pushSrc != 2'd2));

  p_status_restore_r4: assert property (@(posedge clk) disable iff (!rstN)
    pullStatusStb |=> statusFlags == ($past(pullStatusData) & 8'hCF));

  p_acc_pull_nz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pullAccStb && !pullStatusStb) |=>
      statusFlags[1] == ($past(pullAccData) == 8'h00) &&
      statusFlags[7] == $past(pullAccData[7]));

  p_push_sets_i_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && (pushSrc == 2'd1 || pushSrc == 2'd2) && !pullStatusStb) |=>
      statusFlags[2]);
endmodule

bind cpu_flag_unit cpu_flag_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushSrc(pushSrc),
  .pullStatusStb(pullStatusStb), .pullStatusData(pullStatusData),
  .pullAccStb(pullAccStb), .pullAccData(pullAccData),
  .statusFlags(statusFlags), .stackImage(stackImage)
);

// File: tb/cpu_flag_unit_tb_top.sv
module cpu_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushReq = 1'b0;
  logic [1:0] pushSrc = 2'd0;
  logic       pullStatusStb = 1'b0;
  logic [7:0] pullStatusData = 8'h00;
  logic       pullAccStb = 1'b0;
  logic [7:0] pullAccData = 8'h00;
  logic [7:0] flagSetMask = 8'h00;
  logic [7:0] flagClrMask = 8'h00;
  logic [7:0] statusFlags;
  logic [7:0] stackImage;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_flag_unit dut_i (.*);

  // {push, src, pullSt, stData, pullAcc, accData, set, clr, expImage(pre-edge), expFlags(post-edge)}
  localparam int NV = 19;
  localparam logic [52:0] VEC [0:NV-1] = '{
    {1'b0,2'd0,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,8'h34,8'h04}, // R1 reset image
    {1'b0,2'd0,1'b1,8'h00,1'b0,8'h00,8'h00,8'h00,8'h34,8'h00}, // R4 restore zero
    {1'b0,2'd0,1'b0,8'h00,1'b0,8'h00,8'h02,8'h00,8'h30,8'h02}, // R5 image 0x30, R9 set Z
    {1'b0,2'd0,1'b0,8'h00,1'b1,8'h30,8'h00,8'h00,8'h32,8'h00}, // R7 image pulled, Z clear
    {1'b0,2'd0,1'b0,8'h00,1'b1,8'h00,8'h00,8'h00,8'h30,8'h02}, // R6 zero byte
    {1'b0,2'd0,1'b0,8'h00,1'b1,8'h80,8'h00,8'h00,8'h32,8'h80}, // R6 negative byte
    {1'b0,2'd0,1'b0,8'h00,1'b0,8'h00,8'h41,8'h00,8'hB0,8'hC1}, // R9 set V,C
    {1'b0,2'd0,1'b0,8'h00,1'b1,8'h7F,8'h08,8'h00,8'hF1,8'h49}, // R6 others kept
    {1'b1,2'd2,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,8'h69,8'h4D}, // R3 R8 interrupt push
    {1'b0,2'd1,1'b0,8'h00,1'b0,8'h00,8'h00,8'h04,8'h7D,8'h49}, // R2 clear I
    {1'b1,2'd1,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,8'h79,8'h4D}, // R3 R8 break push
    {1'b0,2'd0,1'b0,8'h00,1'b0,8'h00,8'h00,8'hFF,8'h7D,8'h00}, // R9 clear all
    {1'b1,2'd0,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,8'h30,8'h00}, // R8 soft push keeps I
    {1'b0,2'd0,1'b0,8'h00,1'b0,8'h00,8'hFF,8'hFF,8'h30,8'hCF}, // R9 set wins, 5/4 ignored
    {1'b1,2'd2,1'b0,8'h00,1'b0,8'h00,8'h00,8'h04,8'hEF,8'hCF}, // R11 push beats clear
    {1'b1,2'd2,1'b1,8'h30,1'b1,8'h00,8'hFF,8'h00,8'hEF,8'h00}, // R10 status pull wins
    {1'b0,2'd0,1'b0,8'h00,1'b1,8'h00,8'h80,8'h02,8'h30,8'h02}, // R11 acc beats masks
    {1'b0,2'd0,1'b1,8'hFF,1'b0,8'h00,8'h00,8'h00,8'h32,8'hCF}, // R4 bits 5/4 dropped
    {1'b0,2'd3,1'b0,8'h00,1'b0,8'h00,8'h00,8'h00,8'hFF,8'hCF}  // R3 code 3 as software
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pushReq = 0; pushSrc = 0; pullStatusStb = 0; pullAccStb = 0;
    flagSetMask = 0; flagClrMask = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", statusFlags, 8'h04);
    rstN = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {pushReq, pushSrc, pullStatusStb, pullStatusData, pullAccStb, pullAccData,
       flagSetMask, flagClrMask} = VEC[k][52:16];
      #1;
      check($sformatf("R2 image vec %0d", k), stackImage, VEC[k][15:8]);
      @(posedge clk);
      #1;
      check($sformatf("flags vec %0d", k), statusFlags, VEC[k][7:0]);
    end
    // R8: I set only after the edge; image in push cycle shows old I
    @(negedge clk); idle(); flagClrMask = 8'h04;
    @(negedge clk); idle(); pushReq = 1; pushSrc = 2'd2;
    #1 check("R8 pre-edge I in image", stackImage & 8'h04, 8'h00);
    @(posedge clk); #1 check("R8 I after push", statusFlags & 8'h04, 8'h04);
    // R1: reset in the middle of operation
    @(negedge clk); idle(); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1 check("R1 flags after reset", statusFlags, 8'h04);
    check("R1 image after reset", stackImage, 8'h34);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule